// File: doc/BRIEF.md
# Triggered Ring-Buffer Capture Engine

This block records two streams of 14-bit two's complement samples into a pair of circular sample memories. Recording starts when the host arms the engine, and stored samples may be thinned by a selectable decimation ratio. The host then chooses a trigger source. Once that trigger fires, the engine writes a programmed number of further samples and then halts by itself.

The trigger-source register doubles as the busy flag. It reads back the selected source while a capture is pending and drops to zero the moment recording stops. The write address of the triggering sample is latched. To extract the post-trigger window, a host polls the source register until it reads zero. It then reads the latched address and fetches the window through the read port, wrapping modulo the buffer depth. The depth is `2**ADDR_W`; a full-size instance uses `ADDR_W` = 14, which gives 16384 entries.

Top module: `trig_capture`

## Requirements
- R1: After the reset input is asserted, the source readback is 0, the write pointer is 0 and the latched trigger pointer is 0.
- R2: A write to select 0 while armed and not yet triggered stores bits [2:0] as the source, and the source output reads it back. The source codes are 0 idle/done, 1 immediate, 2 channel A rising, 3 channel A falling, 4 channel B rising, 5 channel B falling, 6 external input 0, and 7 external input 1.
- R3: When capture finishes, the source output returns to 0 without any host action, and the write pointer stops advancing until the next arm.
- R4: Let D be the programmed post-trigger length (select 3). Exactly D samples are stored starting with the triggering sample, so the final write pointer equals the trigger address plus D, modulo the depth.
- R5: The write address of the triggering sample is latched and read out on the trigger-pointer output. Later qualifying events in the same capture leave it unchanged.
- R6: Channel triggers compare signed decimated samples against a signed per-channel threshold (select 1 for A, select 2 for B). Rising fires when the previous sample is below the threshold and the current sample is at or above it. Falling fires when the previous sample is above the threshold and the current sample is at or below it. Only samples taken since the last arm count as "previous".
- R7: Select 4 takes a ratio code in which 0, 1, 2, 3, 4 and 5 select 1, 8, 64, 1024, 8192 and 65536 clocks per stored sample; codes 6 and 7 are ignored. Exactly one sample is stored per period, namely the one present at the period's last clock.
- R8: Each accepted sample is written at the write pointer, which then increments modulo the depth. Reading an address returns that entry's channel A and channel B samples one clock later.
- R9: A post-trigger length write whose value is 0, or does not fit in `ADDR_W` bits, is ignored; the reset value is 1.
- R10: A source write made while not armed is ignored, and the write pointer stays put.
- R11: An external trigger is passed through a two-flop synchronizer and fires on its rising edge. At a ratio of 1, an input that rises just before the clock edge of stored sample j triggers on sample j+2.
- R12: Select 5 is control: bit 0 arms, and bit 1 is a soft reset that has priority over bit 0. Arming restarts decimation and clears the previous-sample history. Soft reset stops capture and clears the source, the write pointer and the latched pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adc_a_i | input | SAMPLE_W | Channel A sample |
| adc_b_i | input | SAMPLE_W | Channel B sample |
| ext_trig_i | input | 2 | Asynchronous external trigger inputs |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | REG_W | Register write data |
| trig_src_o | output | 3 | Active source, 0 when idle or done |
| trig_ptr_o | output | ADDR_W | Address of the triggering sample |
| wr_ptr_o | output | ADDR_W | Current write pointer |
| rd_addr_i | input | ADDR_W | Buffer read address |
| rd_data_a_o | output | SAMPLE_W | Channel A entry, one clock after the address |
| rd_data_b_o | output | SAMPLE_W | Channel B entry, one clock after the address |

## Verification
Captures use random sample streams with a planted threshold crossing. These show whether the engine picks the first qualifying crossing and stores exactly D samples from it, and they include lengths that wrap the ring. Directed streams that sit exactly on the threshold, or step just across it, separate the at-or-above and at-or-below rules from strict comparison; negative thresholds expose unsigned compares. At ratios 8 and 64, the bench drives junk samples on non-strobe clocks, which reveals whether the engine stores the wrong clock's sample or stores more than one sample per period. Immediate and external triggers pin down the one-sample and synchronizer latencies.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

   typedef enum logic [2:0] {
      SRC_OFF  = 3'd0,
      SRC_NOW  = 3'd1,
      SRC_A_UP = 3'd2,
      SRC_A_DN = 3'd3,
      SRC_B_UP = 3'd4,
      SRC_B_DN = 3'd5,
      SRC_X0   = 3'd6,
      SRC_X1   = 3'd7
   } trig_src_e;

   localparam logic [2:0] SEL_SRC = 3'd0;
   localparam logic [2:0] SEL_THA = 3'd1;
   localparam logic [2:0] SEL_THB = 3'd2;
   localparam logic [2:0] SEL_DLY = 3'd3;
   localparam logic [2:0] SEL_DEC = 3'd4;
   localparam logic [2:0] SEL_CTL = 3'd5;

   localparam int CTL_ARM_BIT = 0;
   localparam int CTL_RST_BIT = 1;

   // ratio code -> log2 of clocks per stored sample
   function automatic logic [4:0] dec_shift(input logic [2:0] code);
      logic [4:0] s;
      case (code)
         3'd0:    s = 5'd0;
         3'd1:    s = 5'd3;
         3'd2:    s = 5'd6;
         3'd3:    s = 5'd10;
         3'd4:    s = 5'd13;
         default: s = 5'd16;
      endcase
      return s;
   endfunction

   function automatic logic dec_code_ok(input logic [2:0] code);
      return code <= 3'd5;
   endfunction

endpackage

// File: rtl/trig_decim.sv
module trig_decim #(
   parameter int CNT_W = 17
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       restart_i,
   input  logic       run_i,
   input  logic [4:0] shift_i,
   output logic       stb_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   assign reload = (CNT_W'(1) << shift_i) - CNT_W'(1);
   assign stb_o  = run_i && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (stb_o) begin
         cnt_q <= reload;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
   parameter int SAMPLE_W = 14
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                clear_i,
   input  logic                stb_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic [SAMPLE_W-1:0] thr_i,
   output logic                rise_o,
   output logic                fall_o
);
   logic [SAMPLE_W-1:0] prev_q;
   logic                vld_q;
   logic                prev_lt, prev_gt, cur_ge, cur_le;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
         vld_q  <= 1'b0;
      end else if (clear_i) begin
         vld_q  <= 1'b0;
      end else if (stb_i) begin
         prev_q <= sample_i;
         vld_q  <= 1'b1;
      end
   end

   assign prev_lt = $signed(prev_q)   <  $signed(thr_i);
   assign prev_gt = $signed(prev_q)   >  $signed(thr_i);
   assign cur_ge  = $signed(sample_i) >= $signed(thr_i);
   assign cur_le  = $signed(sample_i) <= $signed(thr_i);

   assign rise_o = vld_q && prev_lt && cur_ge;
   assign fall_o = vld_q && prev_gt && cur_le;
endmodule

// File: rtl/trig_ext_sync.sv
module trig_ext_sync (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   logic [2:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], async_i};
   end

   assign rise_o = sh_q[1] && !sh_q[2];
endmodule

// File: rtl/trig_ring.sv
module trig_ring #(
   parameter int SAMPLE_W = 14,
   parameter int ADDR_W   = 10
) (
   input  logic                clk_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   waddr_i,
   input  logic [SAMPLE_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0]   raddr_i,
   output logic [SAMPLE_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [SAMPLE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      rdata_o <= mem[raddr_i];
   end
endmodule

// File: rtl/trig_capture.sv
module trig_capture
   import trig_capture_pkg::*;
#(
   parameter int SAMPLE_W  = 14,
   parameter int ADDR_W    = 10,
   parameter int DEC_CNT_W = 17,
   parameter int REG_W     = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [SAMPLE_W-1:0] adc_a_i,
   input  logic [SAMPLE_W-1:0] adc_b_i,
   input  logic [1:0]          ext_trig_i,
   input  logic                cfg_we_i,
   input  logic [2:0]          cfg_sel_i,
   input  logic [REG_W-1:0]    cfg_wdata_i,
   output logic [2:0]          trig_src_o,
   output logic [ADDR_W-1:0]   trig_ptr_o,
   output logic [ADDR_W-1:0]   wr_ptr_o,
   input  logic [ADDR_W-1:0]   rd_addr_i,
   output logic [SAMPLE_W-1:0] rd_data_a_o,
   output logic [SAMPLE_W-1:0] rd_data_b_o
);
   localparam int NCH  = 2;
   localparam int NEXT = 2;

   if (SAMPLE_W < 2 || SAMPLE_W > REG_W) begin : g_bad_sample_w
      $error("trig_capture: SAMPLE_W must lie in 2..REG_W");
   end
   if (ADDR_W < 2 || ADDR_W >= REG_W) begin : g_bad_addr_w
      $error("trig_capture: ADDR_W must lie in 2..REG_W-1");
   end
   if (DEC_CNT_W < 17) begin : g_bad_cnt_w
      $error("trig_capture: DEC_CNT_W must hold a count of 65535");
   end

   // register decode
   logic ctl_wr, soft_rst, arm_cmd, src_wr;
   assign ctl_wr   = cfg_we_i && (cfg_sel_i == SEL_CTL);
   assign soft_rst = ctl_wr && cfg_wdata_i[CTL_RST_BIT];
   assign arm_cmd  = ctl_wr && cfg_wdata_i[CTL_ARM_BIT] && !cfg_wdata_i[CTL_RST_BIT];
   assign src_wr   = cfg_we_i && (cfg_sel_i == SEL_SRC);

   logic [ADDR_W-1:0] delay_q;
   logic [2:0]        dec_code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         delay_q    <= ADDR_W'(1);
         dec_code_q <= 3'd0;
      end else if (cfg_we_i) begin
         if (cfg_sel_i == SEL_DLY && cfg_wdata_i[ADDR_W-1:0] != '0
             && (cfg_wdata_i >> ADDR_W) == '0)
            delay_q <= cfg_wdata_i[ADDR_W-1:0];
         if (cfg_sel_i == SEL_DEC && dec_code_ok(cfg_wdata_i[2:0])
             && (cfg_wdata_i >> 3) == '0)
            dec_code_q <= cfg_wdata_i[2:0];
      end
   end

   // engine state
   logic              armed_q, trig_q, pend_q;
   trig_src_e         src_q;
   logic [ADDR_W-1:0] wr_ptr_q, trig_ptr_q, remain_q;
   logic              stb, hit;

   trig_decim #(.CNT_W(DEC_CNT_W)) u_decim (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (arm_cmd || soft_rst),
      .run_i     (armed_q),
      .shift_i   (dec_shift(dec_code_q)),
      .stb_o     (stb)
   );

   // per-channel threshold, edge detector and sample memory
   logic [NCH-1:0]                rise, fall;
   logic [NCH-1:0][SAMPLE_W-1:0]  samp, rdat;
   assign samp[0] = adc_a_i;
   assign samp[1] = adc_b_i;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam logic [2:0] THR_SEL = (ch == 0) ? SEL_THA : SEL_THB;
      logic [SAMPLE_W-1:0] thr_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                 thr_q <= '0;
         else if (cfg_we_i && cfg_sel_i == THR_SEL)   thr_q <= cfg_wdata_i[SAMPLE_W-1:0];
      end

      trig_edge #(.SAMPLE_W(SAMPLE_W)) u_edge (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .clear_i  (arm_cmd || soft_rst),
         .stb_i    (stb),
         .sample_i (samp[ch]),
         .thr_i    (thr_q),
         .rise_o   (rise[ch]),
         .fall_o   (fall[ch])
      );

      trig_ring #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_ring (
         .clk_i   (clk_i),
         .we_i    (stb),
         .waddr_i (wr_ptr_q),
         .wdata_i (samp[ch]),
         .raddr_i (rd_addr_i),
         .rdata_o (rdat[ch])
      );
   end

   assign rd_data_a_o = rdat[0];
   assign rd_data_b_o = rdat[1];

   // external triggers
   logic [NEXT-1:0] ext_rise;
   for (genvar e = 0; e < NEXT; e++) begin : g_ext
      trig_ext_sync u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .async_i(ext_trig_i[e]),
         .rise_o (ext_rise[e])
      );
   end

   logic ext_mode, ext_now;
   assign ext_mode = (src_q == SRC_X0) || (src_q == SRC_X1);
   assign ext_now  = ext_mode && ext_rise[src_q[0]];

   always_comb begin
      case (src_q)
         SRC_NOW:  hit = 1'b1;
         SRC_A_UP: hit = rise[0];
         SRC_A_DN: hit = fall[0];
         SRC_B_UP: hit = rise[1];
         SRC_B_DN: hit = fall[1];
         SRC_X0,
         SRC_X1:   hit = ext_now || pend_q;
         default:  hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q    <= 1'b0;
         trig_q     <= 1'b0;
         pend_q     <= 1'b0;
         src_q      <= SRC_OFF;
         wr_ptr_q   <= '0;
         trig_ptr_q <= '0;
         remain_q   <= '0;
      end else if (soft_rst) begin
         armed_q    <= 1'b0;
         trig_q     <= 1'b0;
         pend_q     <= 1'b0;
         src_q      <= SRC_OFF;
         wr_ptr_q   <= '0;
         trig_ptr_q <= '0;
         remain_q   <= '0;
      end else if (arm_cmd) begin
         armed_q <= 1'b1;
         trig_q  <= 1'b0;
         pend_q  <= 1'b0;
         src_q   <= SRC_OFF;
      end else begin
         if (src_wr && armed_q && !trig_q) begin
            src_q  <= trig_src_e'(cfg_wdata_i[2:0]);
            pend_q <= 1'b0;
         end else if (armed_q && !trig_q && ext_now && !stb) begin
            pend_q <= 1'b1;
         end
         if (stb) begin
            wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
            if (!trig_q && hit) begin
               trig_ptr_q <= wr_ptr_q;
               pend_q     <= 1'b0;
               if (delay_q == ADDR_W'(1)) begin
                  armed_q <= 1'b0;
                  src_q   <= SRC_OFF;
               end else begin
                  trig_q   <= 1'b1;
                  remain_q <= delay_q - ADDR_W'(1);
               end
            end else if (trig_q) begin
               if (remain_q == ADDR_W'(1)) begin
                  armed_q <= 1'b0;
                  trig_q  <= 1'b0;
                  src_q   <= SRC_OFF;
               end else begin
                  remain_q <= remain_q - ADDR_W'(1);
               end
            end
         end
      end
   end

   assign trig_src_o = src_q;
   assign trig_ptr_o = trig_ptr_q;
   assign wr_ptr_o   = wr_ptr_q;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
   parameter int ADDR_W = 10,
   parameter int REG_W  = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cfg_we_i,
   input logic [2:0]        cfg_sel_i,
   input logic              armed_i,
   input logic              trig_i,
   input logic [2:0]        src_i,
   input logic [ADDR_W-1:0] trig_ptr_i,
   input logic [ADDR_W-1:0] wr_ptr_i,
   input logic [ADDR_W-1:0] delay_i
);
   logic ctl_wr;
   assign ctl_wr = cfg_we_i && (cfg_sel_i == 3'd5);

   AST_IDLE_SRC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_i |-> (src_i == 3'd0));                                           // R3
   AST_IDLE_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_i && !ctl_wr) |=> $stable(wr_ptr_i));                            // R3
   AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_i && !ctl_wr) |=> ((wr_ptr_i - $past(wr_ptr_i)) <= ADDR_W'(1)));  // R8
   AST_TRIG_PTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i && !ctl_wr) |=> $stable(trig_ptr_i));                            // R5
   AST_TRIG_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i |-> (armed_i && src_i != 3'd0));                                  // R4
   AST_DELAY_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      delay_i != '0);                                                          // R9
endmodule

bind trig_capture trig_capture_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cfg_we_i   (cfg_we_i),
   .cfg_sel_i  (cfg_sel_i),
   .armed_i    (armed_q),
   .trig_i     (trig_q),
   .src_i      (src_q),
   .trig_ptr_i (trig_ptr_q),
   .wr_ptr_i   (wr_ptr_q),
   .delay_i    (delay_q)
);

// File: tb/trig_capture_tb_top.sv
module trig_capture_tb_top;
   localparam int AW    = 8;
   localparam int DEPTH = 1 << AW;
   localparam int SW    = 14;
   localparam int MAXK  = 320;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [SW-1:0]   adc_a = '0, adc_b = '0;
   logic [1:0]      ext = '0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_sel = '0;
   logic [15:0]     cfg_wdata = '0;
   logic [2:0]      trig_src;
   logic [AW-1:0]   trig_ptr, wr_ptr, rd_addr = '0;
   logic [SW-1:0]   rd_a, rd_b;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   int thra = 0, thrb = 0;
   logic [SW-1:0] sa [MAXK];
   logic [SW-1:0] sb [MAXK];

   always #2 clk = ~clk;

   trig_capture #(.SAMPLE_W(SW), .ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .adc_a_i(adc_a), .adc_b_i(adc_b),
      .ext_trig_i(ext), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
      .cfg_wdata_i(cfg_wdata), .trig_src_o(trig_src), .trig_ptr_o(trig_ptr),
      .wr_ptr_o(wr_ptr), .rd_addr_i(rd_addr), .rd_data_a_o(rd_a),
      .rd_data_b_o(rd_b)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] sel, input logic [15:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int sv(input logic [SW-1:0] x);
      return int'($signed(x));
   endfunction

   // expected index of the triggering stored sample (R6, R11)
   function automatic int find_k(input int src, input int ext_at);
      if (src == 1) return 1;
      if (src >= 6) return ext_at + 2;
      for (int k = 1; k < MAXK; k++) begin
         case (src)
            2: if (sv(sa[k-1]) <  thra && sv(sa[k]) >= thra) return k;
            3: if (sv(sa[k-1]) >  thra && sv(sa[k]) <= thra) return k;
            4: if (sv(sb[k-1]) <  thrb && sv(sb[k]) >= thrb) return k;
            5: if (sv(sb[k-1]) >  thrb && sv(sb[k]) <= thrb) return k;
            default: ;
         endcase
      end
      return -1;
   endfunction

   task automatic fill_random();
      for (int k = 0; k < MAXK; k++) begin
         sa[k] = SW'($urandom);
         sb[k] = SW'($urandom);
      end
   endtask

   task automatic run_capture(input int src, input int ratio, input int dly,
                              input int ext_at, input string ctx);
      int p0, kt, klast;
      kt = find_k(src, ext_at);
      p0 = int'(wr_ptr);
      reg_wr(3'd5, 16'd1);                        // arm (R12)
      cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'(src);
      adc_a = sa[0]; adc_b = sb[0];
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      chk(int'(trig_src) == src, {"R2 source readback ", ctx}, int'(trig_src), src);
      klast = -1;
      for (int k = 1; k < MAXK && klast < 0; k++) begin
         for (int j = 0; j < ratio; j++) begin
            if (j == ratio - 1) begin adc_a = sa[k]; adc_b = sb[k]; end
            else begin adc_a = SW'($urandom); adc_b = SW'($urandom); end
            if (src == 6) ext[0] = (k >= ext_at);
            if (src == 7) ext[1] = (k >= ext_at);
            @(posedge clk); @(negedge clk);
         end
         if (trig_src == 3'd0) klast = k;
      end
      chk(klast == kt + dly - 1, {"R4 stop sample index ", ctx}, klast, kt + dly - 1);
      chk(int'(trig_ptr) == (p0 + kt) % DEPTH, {"R5 latched pointer ", ctx},
          int'(trig_ptr), (p0 + kt) % DEPTH);
      chk(int'(wr_ptr) == (p0 + kt + dly) % DEPTH, {"R4 final pointer ", ctx},
          int'(wr_ptr), (p0 + kt + dly) % DEPTH);
      ext = '0;
      for (int i = 0; i < 2 * ratio + 4; i++) begin
         adc_a = SW'($urandom); adc_b = SW'($urandom);
         @(posedge clk); @(negedge clk);
      end
      chk(int'(wr_ptr) == (p0 + kt + dly) % DEPTH, {"R3 pointer frozen ", ctx},
          int'(wr_ptr), (p0 + kt + dly) % DEPTH);
      chk(trig_src == 3'd0, {"R3 source cleared ", ctx}, int'(trig_src), 0);
      for (int i = 0; i < dly; i++) begin
         rd_addr = AW'((p0 + kt + i) % DEPTH);
         @(posedge clk); @(negedge clk);
         chk(rd_a == sa[kt + i], {"R8 window A ", ctx}, sv(rd_a), sv(sa[kt + i]));
         chk(rd_b == sb[kt + i], {"R8 window B ", ctx}, sv(rd_b), sv(sb[kt + i]));
      end
   endtask

   task automatic set_thr(input int a, input int b);
      thra = a; thrb = b;
      reg_wr(3'd1, 16'(a));
      reg_wr(3'd2, 16'(b));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(trig_src == 3'd0, "R1 reset source", int'(trig_src), 0);
      chk(wr_ptr == '0, "R1 reset write pointer", int'(wr_ptr), 0);
      chk(trig_ptr == '0, "R1 reset trigger pointer", int'(trig_ptr), 0);

      // immediate trigger
      fill_random();
      reg_wr(3'd3, 16'd4);
      run_capture(1, 1, 4, 0, "R2 immediate");

      // directed: rising exactly at threshold
      fill_random();
      set_thr(100, 0);
      sa[0] = 14'd100; sa[1] = 14'd100; sa[2] = 14'd99; sa[3] = 14'd100;
      reg_wr(3'd3, 16'd3);
      run_capture(2, 1, 3, 0, "R6 rise at threshold");

      // directed: falling with negative threshold
      fill_random();
      set_thr(-50, 0);
      sa[0] = SW'(-50); sa[1] = SW'(-51); sa[2] = SW'(-49); sa[3] = SW'(-50);
      run_capture(3, 1, 3, 0, "R6 fall at negative threshold");

      // long window across the ring end
      fill_random();
      set_thr(0, -300);
      sb[29] = SW'(-301); sb[30] = SW'(-300);
      reg_wr(3'd3, 16'd200);
      run_capture(4, 1, 200, 0, "R8 wrap B rise");

      // length 0 is ignored: still 200; then oversized also ignored
      reg_wr(3'd3, 16'd0);
      reg_wr(3'd3, 16'd300);
      fill_random();
      set_thr(0, 777);
      sb[29] = SW'(778); sb[30] = SW'(777);
      run_capture(5, 1, 200, 0, "R9 zero length ignored");

      // decimation 8, then invalid code 6 ignored
      reg_wr(3'd3, 16'd10);
      reg_wr(3'd4, 16'd1);
      fill_random();
      set_thr(-1000, 0);
      sa[29] = SW'(-1001); sa[30] = SW'(-1000);
      run_capture(2, 8, 10, 0, "R7 ratio 8");
      reg_wr(3'd4, 16'd6);
      fill_random();
      set_thr(1200, 0);
      sa[29] = SW'(1201); sa[30] = SW'(1200);
      run_capture(3, 8, 10, 0, "R7 code 6 ignored");

      // decimation 64
      reg_wr(3'd4, 16'd2);
      reg_wr(3'd3, 16'd3);
      fill_random();
      run_capture(1, 64, 3, 0, "R7 ratio 64");

      // external triggers
      reg_wr(3'd4, 16'd0);
      reg_wr(3'd3, 16'd6);
      fill_random();
      run_capture(6, 1, 6, 10, "R11 external 0");
      fill_random();
      run_capture(7, 1, 6, 5, "R11 external 1");

      // random captures on channel triggers
      for (int it = 0; it < 6; it++) begin
         int src, dly, a, b;
         src = 2 + int'($urandom % 4);
         dly = 1 + int'($urandom % 255);
         a = int'($urandom % 8001) - 4000;
         b = int'($urandom % 8001) - 4000;
         fill_random();
         set_thr(a, b);
         case (src)
            2: begin sa[29] = SW'(a - 1); sa[30] = SW'(a); end
            3: begin sa[29] = SW'(a + 1); sa[30] = SW'(a); end
            4: begin sb[29] = SW'(b - 1); sb[30] = SW'(b); end
            default: begin sb[29] = SW'(b + 1); sb[30] = SW'(b); end
         endcase
         reg_wr(3'd3, 16'(dly));
         run_capture(src, 1, dly, 0, "R6 random");
      end

      // soft reset, then source write while idle is ignored
      reg_wr(3'd5, 16'd3);
      chk(wr_ptr == '0, "R12 soft reset write pointer", int'(wr_ptr), 0);
      chk(trig_ptr == '0, "R12 soft reset trigger pointer", int'(trig_ptr), 0);
      reg_wr(3'd0, 16'd1);
      repeat (5) @(negedge clk);
      chk(trig_src == 3'd0, "R10 source write while idle", int'(trig_src), 0);
      chk(wr_ptr == '0, "R10 pointer still while idle", int'(wr_ptr), 0);
      reg_wr(3'd3, 16'd1);
      fill_random();
      run_capture(1, 1, 1, 0, "R12 capture after soft reset");

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule